// File: doc/BRIEF.md
# Reference-Gated Frequency Counter

This block measures how fast a test clock runs by counting its divided ticks between rising edges of a slow reference signal. The block runs entirely on the test clock (`clk`). A programmable prescaler divides that clock by N before it reaches an up-counter. Every rising edge of the reference does three things. It latches the tick count since the previous edge as the period. It latches the ticks spent with the reference high as the width. It then restarts the counter and the prescaler from zero, so each period is captured on its own.

A measurement is armed with `measStart`. The first reference edge after arming only aligns the counter and is thrown away. The second edge produces the result: the captured period multiplied by N. The block then reports done and stops measuring until it is armed again. If the counter wraps inside a period, that capture is marked as overflowed, and a result taken from it is flagged as not valid.

The reference can come from a pin or from an internal generator. The generator is a prescaled counter that wraps at a compare value. With the default parameters and a 4 MHz clock it produces one rising edge per second. The generator stays silent until it is started, and an external restart pulse resets its phase.

Top module: `freq_counter`

## Requirements
- R1: After reset, periodCap, widthCap, capPulse, capFlag, capOvf, measDone, freqResult and resultOk are all 0.
- R2: A rising edge of the selected reference loads periodCap with floor(P/N) at the clock edge that first samples the reference high. P is the number of clock edges since the previous rising edge. N is divFactor, and a value of 0 acts as 1. capPulse is high for that one cycle.
- R3: On the same edge, widthCap is loaded with floor(H/N), where H is the number of edges in the previous period that sampled the reference high.
- R4: After measStart, the first reference rising edge leaves measDone at 0. The second edge sets measDone and loads freqResult with that capture's period value times N. Later edges leave freqResult unchanged until the next measStart.
- R5: measDone stays at 1 until measStart. measStart clears measDone and resultOk at the next edge and re-arms the measurement.
- R6: capFlag is set by each capture and cleared by a capFlagClr pulse. When a capture and a clear fall in the same cycle, the flag ends up set.
- R7: If a period holds 2^CNTW ticks or more, capOvf is 1 for that capture and periodCap holds the tick count modulo 2^CNTW. A result taken from such a capture has resultOk = 0, and otherwise resultOk = 1.
- R8: With refSel = 1 the internal generator is the reference. It gives no edge before genStart. After genStart its first rising edge is sampled on the next clock edge. It then repeats every PRESC*MATCH cycles and stays high for PRESC*floor(MATCH/2) of them.
- R9: A genRetrig pulse restarts the generator phase. The reference rises again, and is sampled on the edge after the one that sampled genRetrig.
- R10: While refSel = 1, activity on extRef produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all logic runs on it |
| rstN | input | 1 | Active-low synchronous reset |
| divFactor | input | DIVW | Tick divider N (0 acts as 1) |
| refSel | input | 1 | 1 selects the internal generator, 0 selects extRef |
| extRef | input | 1 | External reference level, synchronous to clk |
| genStart | input | 1 | Starts the internal generator from phase zero |
| genRetrig | input | 1 | Restarts the internal generator phase |
| measStart | input | 1 | Arms a new measurement |
| capFlagClr | input | 1 | Clears capFlag |
| periodCap | output | CNTW | Last captured period in ticks |
| widthCap | output | CNTW | Last captured high time in ticks |
| capPulse | output | 1 | One-cycle strobe on each capture |
| capFlag | output | 1 | Sticky capture flag |
| capOvf | output | 1 | Last capture saw a counter wrap |
| measDone | output | 1 | Measurement finished |
| freqResult | output | CNTW+DIVW | Period times divider for the finished measurement |
| resultOk | output | 1 | freqResult came from a capture without wrap |

## Verification
Two pairs of functions can land in the same clock cycle. One pair is a capture that sets capFlag and a software clear of the same flag. The bench drives capFlagClr on exactly the edge where the reference first reads high, and expects the flag to read 1 afterwards. The other pair is a counter wrap and the capture edge itself. A period of exactly 2^CNTW ticks makes the carry happen on the capture cycle, so the bench expects a zero period with the overflow mark set. A period one tick shorter is expected to show no overflow.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
  // strobes from the measurement control to the datapath
  typedef struct packed {
    logic takeResult;   // latch the current capture as the final result
    logic clearResult;  // drop the validity of the previous result
  } fcStrobe_t;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_WAIT = 2'd1,
    MS_MEAS = 2'd2
  } measState_t;
endpackage

// File: rtl/fcnt_refgen.sv
module fcnt_refgen #(
  parameter int PRESC = 256,
  parameter int MATCH = 15625
) (
  input  logic clk,
  input  logic rstN,
  input  logic genStart,
  input  logic genRetrig,
  output logic genLevel
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam int MW = (MATCH > 1) ? $clog2(MATCH) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);
  localparam logic [MW-1:0] MLAST = MW'(MATCH - 1);
  localparam logic [MW-1:0] HALFV = MW'(MATCH / 2);

  logic          running;
  logic [PW-1:0] prescCnt;
  logic [MW-1:0] mainCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      prescCnt <= '0;
      mainCnt  <= '0;
    end else begin
      if (genStart) running <= 1'b1;
      if (genStart || genRetrig) begin
        prescCnt <= '0;
        mainCnt  <= '0;
      end else if (running) begin
        if (prescCnt == PLAST) begin
          prescCnt <= '0;
          mainCnt  <= (mainCnt == MLAST) ? '0 : mainCnt + MW'(1);
        end else begin
          prescCnt <= prescCnt + PW'(1);
        end
      end
    end
  end

  assign genLevel = running && (mainCnt < HALFV);

  // a new reference period only begins from phase zero
  p_rise_at_phase0_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(genLevel) |-> (mainCnt == '0 && prescCnt == '0));
endmodule

// File: rtl/fcnt_datapath.sv
module fcnt_datapath
  import fcnt_pkg::*;
#(
  parameter int CNTW = 32,
  parameter int DIVW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refLevel,
  input  logic [DIVW-1:0]      divFactor,
  input  logic                 capFlagClr,
  input  fcStrobe_t            strobe,
  output logic                 refEvt,
  output logic [CNTW-1:0]      periodCap,
  output logic [CNTW-1:0]      widthCap,
  output logic                 capPulse,
  output logic                 capFlag,
  output logic                 capOvf,
  output logic [CNTW+DIVW-1:0] freqResult,
  output logic                 resultOk
);
  localparam int RW = CNTW + DIVW;

  logic            refPrev;
  logic [DIVW-1:0] divCnt;
  logic [DIVW-1:0] nEff;
  logic            tick;
  logic [CNTW-1:0] count;
  logic [CNTW-1:0] hiCnt;
  logic            ovfRun;
  logic [CNTW:0]   sumW;
  logic [CNTW-1:0] hiSum;
  logic            wrapNow;

  assign nEff    = (divFactor == '0) ? DIVW'(1) : divFactor;
  assign tick    = (divCnt >= nEff - DIVW'(1));
  assign refEvt  = refLevel & ~refPrev;
  assign sumW    = {1'b0, count} + {{CNTW{1'b0}}, tick};
  assign hiSum   = hiCnt + {{(CNTW-1){1'b0}}, tick & refPrev};
  assign wrapNow = sumW[CNTW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev   <= 1'b0;
      divCnt    <= '0;
      count     <= '0;
      hiCnt     <= '0;
      ovfRun    <= 1'b0;
      periodCap <= '0;
      widthCap  <= '0;
      capOvf    <= 1'b0;
      capPulse  <= 1'b0;
      capFlag   <= 1'b0;
    end else begin
      refPrev <= refLevel;
      if (refEvt) begin
        divCnt    <= '0;
        count     <= '0;
        hiCnt     <= '0;
        ovfRun    <= 1'b0;
        periodCap <= sumW[CNTW-1:0];
        widthCap  <= hiSum;
        capOvf    <= ovfRun | wrapNow;
        capPulse  <= 1'b1;
        capFlag   <= 1'b1;
      end else begin
        divCnt   <= tick ? '0 : divCnt + DIVW'(1);
        count    <= sumW[CNTW-1:0];
        hiCnt    <= hiSum;
        ovfRun   <= ovfRun | wrapNow;
        capPulse <= 1'b0;
        if (capFlagClr) capFlag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqResult <= '0;
      resultOk   <= 1'b0;
    end else if (strobe.takeResult) begin
      freqResult <= {{DIVW{1'b0}}, sumW[CNTW-1:0]} * {{CNTW{1'b0}}, nEff};
      resultOk   <= ~(ovfRun | wrapNow);
    end else if (strobe.clearResult) begin
      resultOk   <= 1'b0;
    end
  end

  p_width_le_period_r3: assert property (@(posedge clk) disable iff (!rstN)
    (capPulse && !capOvf) |-> (widthCap <= periodCap));
  p_flag_on_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    capPulse |-> capFlag);
  p_result_moves_on_event_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqResult) |-> $past(refEvt));
  localparam int UNUSED_RW = RW;
endmodule

// File: rtl/fcnt_ctrl.sv
module fcnt_ctrl
  import fcnt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      measStart,
  input  logic      refEvt,
  output fcStrobe_t strobe,
  output logic      measDone
);
  measState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= MS_IDLE;
      measDone <= 1'b0;
    end else if (measStart) begin
      state    <= MS_WAIT;
      measDone <= 1'b0;
    end else begin
      case (state)
        MS_WAIT: if (refEvt) state <= MS_MEAS;
        MS_MEAS: if (refEvt) begin
          state    <= MS_IDLE;
          measDone <= 1'b1;
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clearResult = measStart;
    strobe.takeResult  = (state == MS_MEAS) && refEvt && !measStart;
  end

  p_done_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (measDone && !measStart) |=> measDone);
  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    measStart |=> !measDone);
  p_done_needs_event_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measDone) |-> $past(refEvt));
endmodule

// File: rtl/freq_counter.sv
module freq_counter
  import fcnt_pkg::*;
#(
  parameter int CNTW  = 32,
  parameter int DIVW  = 8,
  parameter int PRESC = 256,
  parameter int MATCH = 15625
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIVW-1:0]      divFactor,
  input  logic                 refSel,
  input  logic                 extRef,
  input  logic                 genStart,
  input  logic                 genRetrig,
  input  logic                 measStart,
  input  logic                 capFlagClr,
  output logic [CNTW-1:0]      periodCap,
  output logic [CNTW-1:0]      widthCap,
  output logic                 capPulse,
  output logic                 capFlag,
  output logic                 capOvf,
  output logic                 measDone,
  output logic [CNTW+DIVW-1:0] freqResult,
  output logic                 resultOk
);
  logic      genLevel;
  logic      refLevel;
  logic      refEvt;
  fcStrobe_t strobe;

  fcnt_refgen #(.PRESC(PRESC), .MATCH(MATCH)) uGen (
    .clk(clk), .rstN(rstN), .genStart(genStart), .genRetrig(genRetrig),
    .genLevel(genLevel)
  );

  assign refLevel = refSel ? genLevel : extRef;

  fcnt_datapath #(.CNTW(CNTW), .DIVW(DIVW)) uPath (
    .clk(clk), .rstN(rstN), .refLevel(refLevel), .divFactor(divFactor),
    .capFlagClr(capFlagClr), .strobe(strobe), .refEvt(refEvt),
    .periodCap(periodCap), .widthCap(widthCap), .capPulse(capPulse),
    .capFlag(capFlag), .capOvf(capOvf), .freqResult(freqResult),
    .resultOk(resultOk)
  );

  fcnt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .measStart(measStart), .refEvt(refEvt),
    .strobe(strobe), .measDone(measDone)
  );
endmodule

// File: tb/tb_freq_counter.sv
module tb_freq_counter;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int PS = 4;
  localparam int MT = 10;
  localparam int RW = CW + DW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, refSel, extRef, genStart, genRetrig, measStart, capFlagClr;
  logic [DW-1:0] divFactor;
  logic [CW-1:0] periodCap, widthCap;
  logic          capPulse, capFlag, capOvf, measDone, resultOk;
  logic [RW-1:0] freqResult;

  freq_counter #(.CNTW(CW), .DIVW(DW), .PRESC(PS), .MATCH(MT)) dut (
    .clk(clk), .rstN(rstN), .divFactor(divFactor), .refSel(refSel),
    .extRef(extRef), .genStart(genStart), .genRetrig(genRetrig),
    .measStart(measStart), .capFlagClr(capFlagClr), .periodCap(periodCap),
    .widthCap(widthCap), .capPulse(capPulse), .capFlag(capFlag),
    .capOvf(capOvf), .measDone(measDone), .freqResult(freqResult),
    .resultOk(resultOk)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {bit chk; int p; int w; bit ovf;} exp_t;
  exp_t expQ[$];
  exp_t popped;
  bit   monOn = 0;
  int   capSeen = 0;

  // monitor: compares every capture against the scoreboard queue
  always @(negedge clk) begin
    if (capPulse) begin
      capSeen++;
      if (monOn) begin
        if (expQ.size() == 0) begin
          check("R2 unexpected capture", 1, 0);
        end else begin
          popped = expQ.pop_front();
          if (popped.chk) begin
            check("R2 period", periodCap, popped.p);
            check("R3 width", widthCap, popped.w);
            check("R7 overflow mark", capOvf, popped.ovf);
          end
        end
      end
    end
  end

  int prevP = 0, prevH = 0, curN = 1, lastP = 0, lastN = 1;
  bit havePrev = 0, lastOvf = 0;

  function automatic int neff(int n);
    return (n == 0) ? 1 : n;
  endfunction

  // driver: one reference pulse, h edges high then l edges low
  task automatic sendPulse(int h, int l, int nNext, bit clrTogether);
    exp_t e2;
    int q;
    @(negedge clk);
    extRef = 1'b1;
    if (clrTogether) capFlagClr = 1'b1;
    if (havePrev) begin
      q = prevP / neff(curN);
      e2.chk = 1;
      e2.ovf = (q >= (1 << CW));
      e2.p = q % (1 << CW);
      e2.w = (prevH / neff(curN)) % (1 << CW);
      lastP = e2.p; lastOvf = e2.ovf; lastN = neff(curN);
    end else begin
      e2.chk = 0; e2.p = 0; e2.w = 0; e2.ovf = 0;
    end
    expQ.push_back(e2);
    @(negedge clk);
    capFlagClr = 1'b0;
    if (clrTogether) check("R6 capture beats clear", capFlag, 1);
    curN = nNext;
    divFactor = DW'(nNext);
    repeat (h - 1) @(negedge clk);
    extRef = 1'b0;
    repeat (l - 1) @(negedge clk);
    prevP = h + l; prevH = h; havePrev = 1;
  endtask

  task automatic startMeas();
    @(negedge clk); measStart = 1'b1;
    @(negedge clk); measStart = 1'b0;
    check("R5 start clears done", measDone, 0);
    check("R5 start clears ok", resultOk, 0);
    prevP += 2;
  endtask

  task automatic clearFlag();
    @(negedge clk); capFlagClr = 1'b1;
    @(negedge clk); capFlagClr = 1'b0;
    check("R6 flag cleared", capFlag, 0);
    prevP += 2;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      check("watchdog expired", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; refSel = 0; extRef = 0; genStart = 0; genRetrig = 0;
    measStart = 0; capFlagClr = 0; divFactor = DW'(1);
    repeat (3) @(negedge clk);
    check("R1 periodCap", periodCap, 0);
    check("R1 widthCap", widthCap, 0);
    check("R1 capPulse", capPulse, 0);
    check("R1 capFlag", capFlag, 0);
    check("R1 capOvf", capOvf, 0);
    check("R1 measDone", measDone, 0);
    check("R1 freqResult", freqResult, 0);
    check("R1 resultOk", resultOk, 0);
    rstN = 1;
    monOn = 1;

    sendPulse(4, 6, 1, 0);      // alignment rise, not checked
    sendPulse(5, 7, 1, 0);      // R2/R3: 10,4
    sendPulse(7, 8, 3, 0);      // 12,5 then N=3
    sendPulse(3, 9, 0, 0);      // 15/3=5, 7/3=2 then N=0 (acts as 1)
    sendPulse(6, 6, 2, 1);      // 12,3 with a clear in the same cycle
    clearFlag();
    sendPulse(128, 128, 1, 0);  // 14/2=7, 6/2=3
    sendPulse(100, 155, 1, 0);  // 256 ticks: wraps on the capture cycle
    sendPulse(100, 200, 1, 0);  // 255 ticks: largest without wrap

    startMeas();
    sendPulse(5, 5, 1, 0);      // first event after arming: discarded
    check("R4 first event not done", measDone, 0);
    sendPulse(6, 4, 2, 0);      // second event: result
    check("R4 done set", measDone, 1);
    check("R4 result", freqResult, lastP * lastN);
    check("R7 result valid", resultOk, !lastOvf);
    sendPulse(5, 5, 1, 0);
    check("R4 result held", freqResult, 10);
    check("R5 done held", measDone, 1);

    startMeas();
    sendPulse(100, 200, 1, 0);
    sendPulse(5, 5, 1, 0);      // second event follows a 300-tick period
    check("R7 done with wrap", measDone, 1);
    check("R7 result invalid", resultOk, 0);
    check("R7 wrapped result", freqResult, 44);
    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", expQ.size(), 0);
    monOn = 0;

    // internal reference phase
    @(negedge clk); refSel = 1'b1; divFactor = DW'(1);
    begin
      int seen0;
      seen0 = capSeen;
      repeat (3) begin
        @(negedge clk); extRef = 1'b1;
        repeat (3) @(negedge clk);
        extRef = 1'b0;
        repeat (3) @(negedge clk);
      end
      repeat (30) @(negedge clk);
      check("R10 extRef ignored", capSeen - seen0, 0);
      check("R8 silent before start", capSeen - seen0, 0);
    end
    startMeas();
    @(negedge clk); genStart = 1'b1;
    @(negedge clk); genStart = 1'b0;
    repeat (41) @(negedge clk);
    check("R8 done after one period", measDone, 1);
    check("R8 period", periodCap, PS * MT);
    check("R8 high time", widthCap, PS * (MT / 2));
    check("R8 result", freqResult, PS * MT);
    repeat (28) @(negedge clk);
    genRetrig = 1'b1;
    @(negedge clk); genRetrig = 1'b0;
    @(negedge clk);
    check("R9 retrigger period", periodCap, 30);
    check("R9 retrigger width", widthCap, PS * (MT / 2));
    check("R4 result unchanged after done", freqResult, PS * MT);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule